// File: doc/BRIEF.md
# Frame MIMO Latency Meter

This block measures how much delay a device under test adds to a multi-cell frame, in a way that ignores the gaps already present between the cells on the way in. Two probe streams feed it. The ingress probe pulses once per arriving cell, at the first bit of that cell, and marks the frame's opening and closing cells. The egress probe pulses once when the last bit of the frame leaves the device. Two configuration inputs give the time one cell takes on the input link and on the output link, both already scaled to clock ticks.

Every count is in clock ticks and is relative to the start of the frame's opening cell. While cells arrive, the block keeps a running ideal-device baseline. This is the earliest time a perfect device could have finished sending the frame, given those arrival times and the two link speeds. When the egress strobe arrives, the block takes the measured first-in-to-last-out interval and subtracts the baseline. It then reports the measured value, the baseline and the difference together with a one-cycle valid pulse.

Only one frame is tracked at a time. An egress strobe that comes too early marks a protocol error, and no result is produced. A negative difference is floored at zero and flagged. A wrap of the tick counter is flagged with the result.

Top module: `frame_latency_meter`

## Requirements
- R1: After a synchronous active-high reset, `res_valid`, `proto_err`, `res_underflow` and `res_overflow` read 0 and the block waits for a frame.
- R2: When idle, a cycle with `in_cell_stb`=1 and `in_first`=1 starts a frame at relative time 0. A cell strobe that arrives k cycles later has relative time k.
- R3: The baseline starts at 0. For each cell at relative time t it becomes max(t, baseline) + cost. The opening cell counts as the first such cell.
- R4: The cost is max(`cit_ticks`, `cot_ticks`), so it is the same whichever link is the faster one.
- R5: The measured latency is the number of cycles from the opening cell strobe to the `out_last_stb` strobe that closes the frame.
- R6: `res_mimo` = measured − baseline. It is 0 when the device adds no delay beyond the ideal.
- R7: `res_measured`, `res_ideal`, `res_mimo` and the flags are updated, and `res_valid` is high for exactly one cycle, in the cycle after the closing `out_last_stb`.
- R8: If `out_last_stb` arrives before a cell with `in_last`=1 has been taken, no result is produced. `proto_err` then goes to 1 and stays at 1 until the next frame start or reset.
- R9: If the measured latency is below the baseline, `res_mimo` is 0 and `res_underflow` is 1 alongside the result.
- R10: If the relative-time counter wraps past its all-ones value while a frame is open, `res_overflow` is 1 alongside that frame's result, and `res_measured` holds the wrapped count.
- R11: Some strobes are ignored. These are cell strobes without `in_first` while idle, cell strobes after the closing cell has been taken, and `out_last_stb` while idle. After a result or an error, the next opening cell starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cit_ticks | input | W | Input-link cell time in ticks |
| cot_ticks | input | W | Output-link cell time in ticks |
| in_cell_stb | input | 1 | First bit of a cell seen at ingress |
| in_first | input | 1 | Qualifies the strobe as the frame's opening cell |
| in_last | input | 1 | Qualifies the strobe as the frame's closing cell |
| out_last_stb | input | 1 | Last bit of the frame seen at egress |
| res_valid | output | 1 | One-cycle result pulse |
| res_measured | output | W | First-in to last-out latency |
| res_ideal | output | W | Ideal-device baseline |
| res_mimo | output | W | Measured minus baseline, floored at 0 |
| res_underflow | output | 1 | Measured was below baseline |
| res_overflow | output | 1 | Tick counter wrapped during the frame |
| proto_err | output | 1 | Sticky early-egress error |

## Verification
On every cycle, the checker watches how the result fields relate to one another. It checks the difference identity, the zero floor together with its underflow flag, that a valid pulse never lasts two cycles, that a pulse only follows an egress strobe, and that reset clears the outputs and an error only rises after an egress strobe. The actual numbers depend on arrival times and link costs, so only the bench's scenarios can show them. These scenarios cover the equal-rate, fast-ingress and slow-ingress cases, cells that wait versus cells that do not, and the wrap and ignored-strobe cases.

// File: rtl/flm_pkg.sv
package flm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_DRAIN   = 2'd2
   } flm_state_e;

endpackage

// File: rtl/flm_timebase.sv
// Relative tick counter: reads 0 on the opening cell, k for k cycles later.
module flm_timebase #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         run,
   output logic [W-1:0] rel_t,
   output logic         wrap
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_q;

   assign rel_t = start ? '0 : cnt_q;
   assign wrap  = run && !start && (cnt_q == ALL_ONES);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= ONE;
      end else if (run) begin
         cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/flm_ideal_acc.sv
// Ideal-device baseline: base = max(t, base) + max(cit, cot) per cell.
module flm_ideal_acc #(
   parameter int W       = 32,
   parameter bit CFG_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] cit,
   input  logic [W-1:0] cot,
   input  logic         start,
   input  logic         cell_upd,
   input  logic [W-1:0] rel_t,
   output logic [W-1:0] base
);
   logic [W-1:0] cost;
   logic [W-1:0] cost_raw;
   logic [W-1:0] from_t;
   logic [W-1:0] base_q;

   assign cost_raw = (cit > cot) ? cit : cot;

   generate
      if (CFG_REG) begin : g_cost_reg
         logic [W-1:0] cost_q;
         always_ff @(posedge clk) begin
            if (rst) cost_q <= '0;
            else     cost_q <= cost_raw;
         end
         assign cost = cost_q;
      end else begin : g_cost_comb
         assign cost = cost_raw;
      end
   endgenerate

   // On the opening cell the previous baseline is treated as zero.
   assign from_t = start ? rel_t : ((rel_t > base_q) ? rel_t : base_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
      end else if (cell_upd) begin
         base_q <= from_t + cost;
      end
   end

   assign base = base_q;
endmodule

// File: rtl/flm_result.sv
// Result stage: difference, zero floor, registered outputs and valid pulse.
module flm_result #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         done,
   input  logic [W-1:0] measured,
   input  logic [W-1:0] ideal,
   input  logic         ovf,
   output logic         res_valid,
   output logic [W-1:0] res_measured,
   output logic [W-1:0] res_ideal,
   output logic [W-1:0] res_mimo,
   output logic         res_underflow,
   output logic         res_overflow
);
   logic         below;
   logic [W-1:0] diff;

   assign below = measured < ideal;
   assign diff  = below ? '0 : (measured - ideal);

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid     <= 1'b0;
         res_measured  <= '0;
         res_ideal     <= '0;
         res_mimo      <= '0;
         res_underflow <= 1'b0;
         res_overflow  <= 1'b0;
      end else begin
         res_valid <= done;
         if (done) begin
            res_measured  <= measured;
            res_ideal     <= ideal;
            res_mimo      <= diff;
            res_underflow <= below;
            res_overflow  <= ovf;
         end
      end
   end
endmodule

// File: rtl/frame_latency_meter.sv
module frame_latency_meter
   import flm_pkg::*;
#(
   parameter int W       = 32,
   parameter bit CFG_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] cit_ticks,
   input  logic [W-1:0] cot_ticks,
   input  logic         in_cell_stb,
   input  logic         in_first,
   input  logic         in_last,
   input  logic         out_last_stb,
   output logic         res_valid,
   output logic [W-1:0] res_measured,
   output logic [W-1:0] res_ideal,
   output logic [W-1:0] res_mimo,
   output logic         res_underflow,
   output logic         res_overflow,
   output logic         proto_err
);
   generate
      if (W < 4 || W > 64) begin : g_bad_width
         $error("frame_latency_meter: W must lie in 4..64");
      end
   endgenerate

   flm_state_e   st_q, st_d;
   logic         start, run, cell_upd, last_now, done, perr_evt;
   logic [W-1:0] rel_t, base;
   logic         wrap;
   logic         ovf_q;
   logic         perr_q;

   assign start    = (st_q == ST_IDLE) && in_cell_stb && in_first;
   assign run      = (st_q != ST_IDLE);
   assign cell_upd = start || ((st_q == ST_COLLECT) && in_cell_stb);
   assign last_now = cell_upd && in_last;
   assign done     = (st_q == ST_DRAIN) && out_last_stb;
   assign perr_evt = (st_q == ST_COLLECT) && out_last_stb;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (start) st_d = last_now ? ST_DRAIN : ST_COLLECT;
         ST_COLLECT: if (perr_evt) st_d = ST_IDLE;
                     else if (last_now) st_d = ST_DRAIN;
         ST_DRAIN:   if (done) st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         ovf_q  <= 1'b0;
         perr_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start)     ovf_q <= 1'b0;
         else if (wrap) ovf_q <= 1'b1;
         if (start)         perr_q <= 1'b0;
         else if (perr_evt) perr_q <= 1'b1;
      end
   end

   assign proto_err = perr_q;

   flm_timebase #(.W(W)) u_time (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .run   (run),
      .rel_t (rel_t),
      .wrap  (wrap)
   );

   flm_ideal_acc #(.W(W), .CFG_REG(CFG_REG)) u_ideal (
      .clk      (clk),
      .rst      (rst),
      .cit      (cit_ticks),
      .cot      (cot_ticks),
      .start    (start),
      .cell_upd (cell_upd),
      .rel_t    (rel_t),
      .base     (base)
   );

   flm_result #(.W(W)) u_res (
      .clk           (clk),
      .rst           (rst),
      .done          (done),
      .measured      (rel_t),
      .ideal         (base),
      .ovf           (ovf_q | wrap),
      .res_valid     (res_valid),
      .res_measured  (res_measured),
      .res_ideal     (res_ideal),
      .res_mimo      (res_mimo),
      .res_underflow (res_underflow),
      .res_overflow  (res_overflow)
   );
endmodule

// File: rtl/flm_checker.sv
module flm_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst,
   input logic         out_last_stb,
   input logic         res_valid,
   input logic [W-1:0] res_measured,
   input logic [W-1:0] res_ideal,
   input logic [W-1:0] res_mimo,
   input logic         res_underflow,
   input logic         proto_err
);
   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!res_valid && !proto_err));

   // R6
   a_r6_difference: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_underflow) |-> (res_measured == res_ideal + res_mimo));

   // R9
   a_r9_floor: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_underflow) |-> (res_mimo == '0 && res_measured < res_ideal));

   // R7
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
      res_valid |=> !res_valid);

   // R7
   a_r7_after_egress: assert property (@(posedge clk) disable iff (rst)
      $rose(res_valid) |-> $past(out_last_stb));

   // R8
   a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(proto_err) |-> $past(out_last_stb));

   // R8
   a_r8_no_result_on_err: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> !proto_err);
endmodule

bind frame_latency_meter flm_checker #(.W(W)) u_flm_chk (
   .clk          (clk),
   .rst          (rst),
   .out_last_stb (out_last_stb),
   .res_valid    (res_valid),
   .res_measured (res_measured),
   .res_ideal    (res_ideal),
   .res_mimo     (res_mimo),
   .res_underflow(res_underflow),
   .proto_err    (proto_err)
);

// File: tb/frame_latency_meter_tb.sv
`timescale 1ns/1ps
module frame_latency_meter_tb;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] cit_ticks, cot_ticks;
   logic         in_cell_stb, in_first, in_last, out_last_stb;
   logic         res_valid, res_underflow, res_overflow, proto_err;
   logic [W-1:0] res_measured, res_ideal, res_mimo;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   frame_latency_meter #(.W(W)) u_dut (
      .clk(clk), .rst(rst), .cit_ticks(cit_ticks), .cot_ticks(cot_ticks),
      .in_cell_stb(in_cell_stb), .in_first(in_first), .in_last(in_last),
      .out_last_stb(out_last_stb), .res_valid(res_valid),
      .res_measured(res_measured), .res_ideal(res_ideal), .res_mimo(res_mimo),
      .res_underflow(res_underflow), .res_overflow(res_overflow),
      .proto_err(proto_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      in_cell_stb = 0; in_first = 0; in_last = 0; out_last_stb = 0;
   endtask

   task automatic set_cfg(input int ci, input int co);
      @(negedge clk);
      cit_ticks = W'(ci); cot_ticks = W'(co);
      @(negedge clk);
   endtask

   // Drives cells at arrival times a0..a(n-1), egress at t_out; samples the
   // cycle after egress (the negedge following the capture edge).
   task automatic run_frame(input int n, input int a0, input int a1, input int a2,
                            input int t_out);
      int arr[3];
      arr[0] = a0; arr[1] = a1; arr[2] = a2;
      for (int k = 0; k <= t_out; k++) begin
         @(negedge clk);
         idle_inputs();
         for (int i = 0; i < n; i++) begin
            if (arr[i] == k) begin
               in_cell_stb = 1;
               in_first    = (i == 0);
               in_last     = (i == n - 1);
            end
         end
         if (k == t_out) out_last_stb = 1;
      end
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic expect_result(input string req, input int m, input int id, input int mi,
                                input int uf, input int ov);
      chk(req, "valid", int'(res_valid), 1);
      chk(req, "measured", int'(res_measured), m);
      chk(req, "ideal", int'(res_ideal), id);
      chk(req, "mimo", int'(res_mimo), mi);
      chk(req, "underflow", int'(res_underflow), uf);
      chk(req, "overflow", int'(res_overflow), ov);
      @(negedge clk);
      chk("R7", "valid drops", int'(res_valid), 0);
   endtask

   task automatic t_reset();
      rst = 1; idle_inputs(); cit_ticks = 1; cot_ticks = 1;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk("R1", "valid after reset", int'(res_valid), 0);
      chk("R1", "proto_err after reset", int'(proto_err), 0);
      chk("R1", "underflow after reset", int'(res_underflow), 0);
      chk("R1", "overflow after reset", int'(res_overflow), 0);
   endtask

   // Equal rates, cell time 1, second cell after a 1-tick gap, device adds 5.
   task automatic t_equal_small_gap();
      set_cfg(1, 1);
      run_frame(2, 0, 2, 0, 8);
      expect_result("R6", 8, 3, 5, 0, 0);
   endtask

   // Equal rates, 5-tick gap, device adds 1: same measured, smaller MIMO.
   task automatic t_equal_big_gap();
      set_cfg(1, 1);
      run_frame(2, 0, 6, 0, 8);
      expect_result("R3", 8, 7, 1, 0, 0);
   endtask

   // Fast ingress: no cell waits, ideal device gives MIMO 0.
   task automatic t_fast_in_nowait();
      set_cfg(1, 4);
      run_frame(2, 0, 5, 0, 9);
      expect_result("R6", 9, 9, 0, 0, 0);
   endtask

   // Fast ingress with waiting cell: baseline 8.
   task automatic t_fast_in_wait();
      set_cfg(1, 4);
      run_frame(2, 0, 2, 0, 11);
      expect_result("R3", 11, 8, 3, 0, 0);
   endtask

   // Slow ingress: cost uses the larger (input) cell time.
   task automatic t_slow_in();
      set_cfg(4, 1);
      run_frame(2, 0, 5, 0, 10);
      expect_result("R4", 10, 9, 1, 0, 0);
   endtask

   // Three cells: t=0,3,4 cost 2 -> 2, 5, 7; egress at 12 -> measured R5.
   task automatic t_three_cells();
      set_cfg(2, 1);
      run_frame(3, 0, 3, 4, 12);
      expect_result("R5", 12, 7, 5, 0, 0);
   endtask

   task automatic t_underflow();
      set_cfg(3, 3);
      run_frame(1, 0, 0, 0, 1);
      expect_result("R9", 1, 3, 0, 1, 0);
   endtask

   task automatic t_proto_err();
      set_cfg(1, 1);
      @(negedge clk); in_cell_stb = 1; in_first = 1;
      @(negedge clk); idle_inputs();
      @(negedge clk); out_last_stb = 1;
      @(negedge clk); idle_inputs();
      chk("R8", "no result", int'(res_valid), 0);
      chk("R8", "error set", int'(proto_err), 1);
      repeat (3) @(negedge clk);
      chk("R8", "error sticky", int'(proto_err), 1);
      run_frame(1, 0, 0, 0, 4);
      chk("R8", "error cleared by new frame", int'(proto_err), 0);
      expect_result("R11", 4, 1, 3, 0, 0);
   endtask

   task automatic t_ignored();
      set_cfg(1, 1);
      // Idle: cell without first, then a stray egress.
      @(negedge clk); in_cell_stb = 1;
      @(negedge clk); idle_inputs(); out_last_stb = 1;
      @(negedge clk); idle_inputs();
      chk("R11", "idle strobes no result", int'(res_valid), 0);
      chk("R11", "idle strobes no error", int'(proto_err), 0);
      // Frame closes at t=0; a stray cell at t=2 must not move the baseline.
      @(negedge clk); in_cell_stb = 1; in_first = 1; in_last = 1;
      @(negedge clk); idle_inputs();
      @(negedge clk); in_cell_stb = 1;
      @(negedge clk); idle_inputs();
      @(negedge clk); out_last_stb = 1;
      @(negedge clk); idle_inputs();
      expect_result("R11", 4, 1, 3, 0, 0);
   endtask

   // Counter wraps at 2^W = 1024 ticks; egress at 1100 reads 76.
   task automatic t_overflow();
      set_cfg(1, 1);
      run_frame(1, 0, 0, 0, 1100);
      expect_result("R10", 76, 1, 75, 0, 1);
      run_frame(1, 0, 0, 0, 3);
      expect_result("R10", 3, 1, 2, 0, 0);
   endtask

   // Opening cell delayed: time base starts at the opening strobe (R2).
   task automatic t_time_origin();
      set_cfg(1, 1);
      repeat (7) @(negedge clk);
      run_frame(2, 0, 1, 0, 2);
      expect_result("R2", 2, 2, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_equal_small_gap();
      t_equal_big_gap();
      t_fast_in_nowait();
      t_fast_in_wait();
      t_slow_in();
      t_three_cells();
      t_underflow();
      t_proto_err();
      t_ignored();
      t_overflow();
      t_time_origin();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule